// File: doc/BRIEF.md
# Vector Element Shuffle Unit

This unit permutes the elements of a 128-bit vector under an 8-bit immediate. The vector is treated as 16 bytes, 8 halfwords or 4 words, depending on a 2-bit format select. The elements are split into groups of four neighbours. Each output element takes one of the four source elements of its own group. Elements never move from one group to another.

The immediate holds four 2-bit selectors, one for each position inside a group. Every group uses the same four selectors, whatever the element width. The caller presents the source, the immediate and the format together with a valid strobe. One cycle later the unit returns the registered result with a valid flag. Format code 3 is illegal: it raises an error flag and returns a zero result. The result is built from the source vector alone; no earlier result feeds into it.

Top module: `vec_shuffle`

## Requirements
- R1: The selector for position p inside a group (p = i mod 4 for output element i) is shufImm[2p+1:2p]. Output element i takes source element 4*(i div 4) + selector. Element 0 is the least significant element of the bus.
- R2: With fmtSel = 0 (byte), the sixteen bytes form four groups. Each group is permuted with the same selectors.
- R3: With fmtSel = 1 (halfword), the eight 16-bit elements form two groups. Both are permuted with the same selectors.
- R4: With fmtSel = 2 (word), the four 32-bit elements form one group. Output word i equals source word sel(i).
- R5: The result depends only on srcVec, shufImm and fmtSel at the accepted strobe. Earlier results have no effect on it.
- R6: When fmtSel = 3 is accepted, fmtErr is 1 and resVec is all zero in the next cycle. Any other accepted format gives fmtErr = 0.
- R7: outValid is 1 in the cycle after inValid is 1, and 0 in the cycle after inValid is 0.
- R8: While inValid is 0, resVec and fmtErr keep their values.
- R9: A synchronous reset (rst = 1 at a clock edge) clears outValid, fmtErr and resVec to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Accept strobe for srcVec, shufImm and fmtSel |
| srcVec | input | 128 | Source vector; element 0 is at the least significant bits |
| shufImm | input | 8 | Four 2-bit selectors; position p uses bits [2p+1:2p] |
| fmtSel | input | 2 | Element width: 0 byte, 1 halfword, 2 word, 3 illegal |
| outValid | output | 1 | Result valid, one cycle after inValid |
| resVec | output | 128 | Registered permuted vector |
| fmtErr | output | 1 | The accepted format was illegal |

## Verification
Two functions can fall in the same cycle, and both are exercised:
- **Back-to-back strobes.** A new strobe can arrive in the same cycle that the previous result is presented. The bench drives strobes on consecutive cycles with changing formats, including illegal-to-legal and legal-to-illegal changes. On every clock a behavioural reference checks that each result reflects only its own inputs.
- **Idle cycles and hold.** Idle cycles are mixed in at random. In those cycles the same reference checks that the result and the error flag hold and that the valid flag drops.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam int GRP   = 4;
  localparam int SEL_W = 2;
  localparam int IMM_W = GRP * SEL_W;
  localparam int NUM_W = 3;

  typedef enum logic [1:0] {
    FMT_BYTE = 2'd0,
    FMT_HALF = 2'd1,
    FMT_WORD = 2'd2,
    FMT_BAD  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic             load;
    logic             clearRes;
    logic [NUM_W-1:0] widthHot;
  } shufCtrl_t;
endpackage

// File: rtl/shuf_ctrl.sv
module shuf_ctrl
  import shuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic [1:0] fmtSel,
  output shufCtrl_t ctrl,
  output logic      outValid,
  output logic      fmtErr
);
  logic badFmt;

  always_comb begin
    badFmt        = (fmtSel == FMT_BAD);
    ctrl.load     = inValid;
    ctrl.clearRes = badFmt;
    ctrl.widthHot = '0;
    unique case (fmtSel)
      FMT_BYTE: ctrl.widthHot[0] = 1'b1;
      FMT_HALF: ctrl.widthHot[1] = 1'b1;
      FMT_WORD: ctrl.widthHot[2] = 1'b1;
      default:  ctrl.widthHot    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      fmtErr   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) fmtErr <= badFmt;
    end
  end
endmodule

// File: rtl/shuf_datapath.sv
module shuf_datapath
  import shuf_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  shufCtrl_t        ctrl,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [IMM_W-1:0] shufImm,
  output logic [VEC_W-1:0] resVec
);
  logic [NUM_W-1:0][VEC_W-1:0] permByWidth;
  logic [VEC_W-1:0]            nextRes;
  logic [VEC_W-1:0]            resReg;

  for (genvar w = 0; w < NUM_W; w++) begin : g_width
    localparam int EW = 8 << w;
    localparam int NL = VEC_W / EW;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      localparam int BASE = (i / GRP) * GRP;
      localparam int POS  = i % GRP;
      logic [SEL_W-1:0] laneSel;
      assign laneSel = shufImm[POS*SEL_W +: SEL_W];
      assign permByWidth[w][i*EW +: EW] = srcVec[(BASE + int'(laneSel))*EW +: EW];
    end
  end

  always_comb begin
    nextRes = '0;
    for (int w = 0; w < NUM_W; w++) begin
      if (ctrl.widthHot[w]) nextRes = permByWidth[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resReg <= '0;
    end else if (ctrl.load) begin
      resReg <= ctrl.clearRes ? '0 : nextRes;
    end
  end

  assign resVec = resReg;
endmodule

// File: rtl/vec_shuffle.sv
module vec_shuffle
  import shuf_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [7:0]       shufImm,
  input  logic [1:0]       fmtSel,
  output logic             outValid,
  output logic [VEC_W-1:0] resVec,
  output logic             fmtErr
);
  shufCtrl_t ctrl;

  shuf_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .fmtSel(fmtSel),
    .ctrl(ctrl), .outValid(outValid), .fmtErr(fmtErr)
  );

  shuf_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .srcVec(srcVec),
    .shufImm(shufImm), .resVec(resVec)
  );
endmodule

// File: rtl/vec_shuffle_chk.sv
module vec_shuffle_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [VEC_W-1:0] srcVec,
  input logic [7:0]       shufImm,
  input logic [1:0]       fmtSel,
  input logic             outValid,
  input logic [VEC_W-1:0] resVec,
  input logic             fmtErr
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) inValid |=> outValid); // R7
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst) !inValid |=> !outValid); // R7
  AST_BAD_FMT_FLAG: assert property (@(posedge clk) disable iff (rst) (inValid && fmtSel == 2'd3) |=> (fmtErr && resVec == '0)); // R6
  AST_GOOD_FMT_FLAG: assert property (@(posedge clk) disable iff (rst) (inValid && fmtSel != 2'd3) |=> !fmtErr); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !inValid |=> ($stable(resVec) && $stable(fmtErr))); // R8
  AST_WORD_IDENTITY: assert property (@(posedge clk) disable iff (rst) (inValid && fmtSel == 2'd2 && shufImm == 8'hE4) |=> resVec == $past(srcVec)); // R4
endmodule

bind vec_shuffle vec_shuffle_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .srcVec(srcVec), .shufImm(shufImm),
  .fmtSel(fmtSel), .outValid(outValid), .resVec(resVec), .fmtErr(fmtErr)
);

// File: tb/tb_vec_shuffle.sv
`timescale 1ns/1ps
module tb_vec_shuffle;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [127:0] srcVec = '0;
  logic [7:0]   shufImm = '0;
  logic [1:0]   fmtSel = '0;
  logic         outValid;
  logic [127:0] resVec;
  logic         fmtErr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  logic         expValid = 1'b0;
  logic         expErr = 1'b0;
  logic [127:0] expRes = '0;
  string        resTag = "R9";

  always #2 clk = ~clk;

  vec_shuffle dut (
    .clk(clk), .rst(rst), .inValid(inValid), .srcVec(srcVec), .shufImm(shufImm),
    .fmtSel(fmtSel), .outValid(outValid), .resVec(resVec), .fmtErr(fmtErr)
  );

  function automatic logic [127:0] shufRef(logic [127:0] s, logic [7:0] imm, logic [1:0] f);
    logic [127:0] r;
    int ew, n, k;
    r = '0;
    if (f == 2'd3) return r;
    ew = 8 << f;
    n = 128 / ew;
    for (int i = 0; i < n; i++) begin
      k = (i / 4) * 4 + ((imm >> (2 * (i % 4))) & 3);
      for (int b = 0; b < ew; b++) r[i*ew + b] = s[k*ew + b];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      expValid = 1'b0; expErr = 1'b0; expRes = '0; resTag = "R9";
    end else if (inValid) begin
      expValid = 1'b1;
      expErr = (fmtSel == 2'd3);
      expRes = shufRef(srcVec, shufImm, fmtSel);
      case (fmtSel)
        2'd0: resTag = "R2";
        2'd1: resTag = "R3";
        2'd2: resTag = "R4";
        default: resTag = "R6";
      endcase
    end else begin
      expValid = 1'b0;
      resTag = "R8";
    end
  end

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkV(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the reference on every clock, away from the edge
  always @(negedge clk) begin
    if (!done && cycles > 0) begin
      chk1("R7 outValid", outValid, expValid);
      chk1(expErr ? "R6 fmtErr" : "R6/R8 fmtErr", fmtErr, expErr);
      chkV(resTag, resVec, expRes);
    end
  end

  task automatic drive(logic v, logic [127:0] s, logic [7:0] imm, logic [1:0] f);
    @(negedge clk);
    #0.5;
    inValid = v; srcVec = s; shufImm = imm; fmtSel = f;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic finishRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk1("R9 outValid", outValid, 1'b0);
    chk1("R9 fmtErr", fmtErr, 1'b0);
    chkV("R9 resVec", resVec, '0);
    #0.5 rst = 1'b0;

    // R1/R4: word reverse, directed expected value
    drive(1'b1, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}, 8'h1B, 2'd2);
    drive(1'b0, '0, 8'h00, 2'd0);
    chkV("R1 word reverse", resVec, {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444});
    // R1/R2: byte broadcast of position 1 in each group (imm 0x55)
    drive(1'b1, 128'h0F0E0D0C_0B0A0908_07060504_03020100, 8'h55, 2'd0);
    drive(1'b0, '0, 8'h00, 2'd0);
    chkV("R2 byte sel1", resVec, 128'h0D0D0D0D_09090909_05050505_01010101);
    // R3: halfword swap pairs (sel = 1,0,3,2 -> imm 0xB1)
    drive(1'b1, 128'h0007_0006_0005_0004_0003_0002_0001_0000, 8'hB1, 2'd1);
    drive(1'b0, '0, 8'h00, 2'd0);
    chkV("R3 half swap", resVec, 128'h0006_0007_0004_0005_0002_0003_0000_0001);
    // R6: illegal format then R5: legal result independent of history
    drive(1'b1, rnd128(), 8'hE4, 2'd3);
    drive(1'b1, 128'hAAAA_BBBB_CCCC_DDDD_1111_2222_3333_4444, 8'hE4, 2'd2);
    drive(1'b0, '0, 8'h00, 2'd0);
    chkV("R5 identity after illegal", resVec, 128'hAAAA_BBBB_CCCC_DDDD_1111_2222_3333_4444);
    chk1("R6 flag cleared", fmtErr, 1'b0);

    // random traffic, back-to-back and idle mixed
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom() % 4) != 0, rnd128(), 8'($urandom()), 2'($urandom()));
    end
    // reset mid-stream: R9
    drive(1'b1, rnd128(), 8'h27, 2'd0);
    @(negedge clk); #0.5 rst = 1'b1; inValid = 1'b0;
    @(negedge clk); #0.5 rst = 1'b0;
    repeat (3) @(negedge clk);
    finishRun();
  end

  initial begin
    wait (cycles > 50000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end
endmodule